// File: doc/BRIEF.md
# Link Integrity Check Monitor

This block watches the periodic link-verification values of an encrypted video link. On each frame the cipher gives it a 16-bit link check word and an 8-bit fast check word. The block counts frames and picks out the frames where a check is due. At each of those frames it sends a read request. When the receiver's copies come back, it compares them with the local words it saved at that frame.

Each kind of problem is reported as its own event:

- a mismatch at the first frame of the 128-frame window;
- a mismatch at the last frame of that window;
- a fast-check mismatch;
- a local word that fails to change across its window;
- a read-back that is late or reports a bus error.

Two periodic tick events mark the long and the short check windows. Every event sets a sticky status bit. Software clears a status bit by writing 1 to it. A per-bit mask decides which status bits drive the interrupt.

Top module: `link_check_mon`

## Requirements
- R1: The frame number starts at 0 and advances by one on each `vsync_i` pulse while `enable_i` is high. After frame 127 it wraps to 0. While `enable_i` is low it is held at 0, so the first pulse after enabling is frame 0.
- R2: Status bit 0 sets on the pulse of frame 127. Status bit 1 sets on every pulse whose frame number has its low four bits equal to 15.
- R3: The cycle after a check-frame pulse, `rd_req_o` is high for one cycle. In `rd_sel_o`, bit 0 means the long check (frames 0 and 127) and bit 1 means the fast check (low nibble 15). Frame 127 sets both bits. No other frame raises `rd_req_o`.
- R4: At frame 0, if `rd_ri_i` differs from the `local_ri_i` sampled at that pulse when the read completes, status bit 2 sets.
- R5: The same long-check mismatch at frame 127 sets status bit 3 instead.
- R6: If `local_ri_i` at the frame-127 pulse equals its value at the frame-0 pulse, status bit 4 sets.
- R7: At any fast-check frame, if `rd_pj_i` differs from the sampled `local_pj_i` when the read completes, status bit 5 sets.
- R8: If `local_pj_i` at the frame-15 pulse equals its value at the frame-0 pulse, status bit 6 sets.
- R9: Status bit 7 sets in three cases: a read is still outstanding at the next `vsync_i`; a `rd_done_i` arrives in the same cycle as that `vsync_i` (it counts as late and is not compared); or `rd_done_i` arrives with `rd_err_i` high. A `rd_done_i` with no read outstanding is ignored. A completed read compares only on its first `rd_done_i`.
- R10: Status bits reset to 0 and stay set until a 1 is written to the same bit of `clr_i`. An event in the same cycle as its clear leaves the bit set.
- R11: `irq_o` is high in the same cycle whenever any status bit and its `unmask_i` bit are both 1.
- R12: While `enable_i` is low, no request is issued and no event is raised, including on `rd_done_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Enables checking; low holds the frame count at 0 |
| vsync_i | input | 1 | One-cycle frame start pulse |
| local_ri_i | input | 16 | Local link check word, valid at `vsync_i` |
| local_pj_i | input | 8 | Local fast check word, valid at `vsync_i` |
| rd_req_o | output | 1 | Read-back request pulse |
| rd_sel_o | output | 2 | Words wanted: bit 0 long check, bit 1 fast check |
| rd_done_i | input | 1 | Read-back complete strobe |
| rd_err_i | input | 1 | Bus error flag with `rd_done_i` |
| rd_ri_i | input | 16 | Receiver link check word |
| rd_pj_i | input | 8 | Receiver fast check word |
| unmask_i | input | 8 | Interrupt enable per status bit |
| clr_i | input | 8 | Write-1-to-clear per status bit |
| status_o | output | 8 | Sticky event status |
| irq_o | output | 1 | Interrupt |

## Verification
Frame 127 packs the most work into one pulse: the long-window tick, the short-window tick, the stuck test on the long word, and one read carrying both words. That one completion must resolve the long-word and fast-word comparisons independently. Vectors put mismatches on one word or on both, and judge status bits 3 and 5 separately after the window ends. A second collision is also driven: a completion strobe lands in the same cycle as the next `vsync_i`. The expected result there is the late-read bit alone, with no mismatch bit even though the returned word is wrong.

// File: rtl/lcm_pkg.sv
`timescale 1ns/1ps
package lcm_pkg;
  localparam int NEV         = 8;
  localparam int EV_RI_TICK  = 0;
  localparam int EV_PJ_TICK  = 1;
  localparam int EV_RI_F0    = 2;
  localparam int EV_RI_FL    = 3;
  localparam int EV_RI_STUCK = 4;
  localparam int EV_PJ_FAIL  = 5;
  localparam int EV_PJ_STUCK = 6;
  localparam int EV_RD_MISS  = 7;
endpackage

// File: rtl/lcm_frame_ctr.sv
`timescale 1ns/1ps
module lcm_frame_ctr #(
  parameter int FC_W   = 7,
  parameter int PJ_LOG = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic vsync_i,
  output logic vs_o,
  output logic ri_first_o,
  output logic ri_last_o,
  output logic pj_pt_o,
  output logic pj_first_o
);
  localparam logic [FC_W-1:0] FC_LAST = '1;
  localparam logic [FC_W-1:0] PJ_LAST = FC_W'((1 << PJ_LOG) - 1);

  logic [FC_W-1:0] fc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      fc_q <= '0;
    else if (!en_i)   fc_q <= '0;
    else if (vsync_i) fc_q <= fc_q + 1'b1;
  end

  assign vs_o       = en_i & vsync_i;
  assign ri_first_o = vs_o && (fc_q == '0);
  assign ri_last_o  = vs_o && (fc_q == FC_LAST);
  assign pj_pt_o    = vs_o && (fc_q[PJ_LOG-1:0] == '1);
  assign pj_first_o = vs_o && (fc_q == PJ_LAST);

  assert_fc_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && vsync_i && fc_q == FC_LAST) |=> (fc_q == '0));
  assert_fc_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (fc_q == '0));
endmodule

// File: rtl/lcm_rd_track.sv
`timescale 1ns/1ps
module lcm_rd_track #(
  parameter int RI_W = 16,
  parameter int PJ_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            vs_i,
  input  logic            ri_first_i,
  input  logic            ri_last_i,
  input  logic            pj_pt_i,
  input  logic [RI_W-1:0] local_ri_i,
  input  logic [PJ_W-1:0] local_pj_i,
  input  logic            rd_done_i,
  input  logic            rd_err_i,
  input  logic [RI_W-1:0] rd_ri_i,
  input  logic [PJ_W-1:0] rd_pj_i,
  output logic            rd_req_o,
  output logic [1:0]      rd_sel_o,
  output logic            ev_ri0_o,
  output logic            ev_ril_o,
  output logic            ev_pj_o,
  output logic            ev_miss_o
);
  logic            pend_ri_q, pend_pj_q, last_q, req_q;
  logic [1:0]      sel_q;
  logic [RI_W-1:0] exp_ri_q;
  logic [PJ_W-1:0] exp_pj_q;
  logic            pend, ri_pt, take, ok;

  assign pend  = pend_ri_q | pend_pj_q;
  assign ri_pt = ri_first_i | ri_last_i;
  // a strobe in the vsync cycle is late: vsync wins
  assign take  = en_i & rd_done_i & pend & ~vs_i;
  assign ok    = take & ~rd_err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_ri_q <= 1'b0;
      pend_pj_q <= 1'b0;
      last_q    <= 1'b0;
      req_q     <= 1'b0;
      sel_q     <= '0;
      exp_ri_q  <= '0;
      exp_pj_q  <= '0;
    end else if (!en_i) begin
      pend_ri_q <= 1'b0;
      pend_pj_q <= 1'b0;
      req_q     <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (vs_i) begin
        pend_ri_q <= ri_pt;
        pend_pj_q <= pj_pt_i;
        last_q    <= ri_last_i;
        req_q     <= ri_pt | pj_pt_i;
        sel_q     <= {pj_pt_i, ri_pt};
        if (ri_pt)   exp_ri_q <= local_ri_i;
        if (pj_pt_i) exp_pj_q <= local_pj_i;
      end else if (take) begin
        pend_ri_q <= 1'b0;
        pend_pj_q <= 1'b0;
      end
    end
  end

  assign rd_req_o  = req_q;
  assign rd_sel_o  = sel_q;
  assign ev_miss_o = (vs_i & pend) | (take & rd_err_i);
  assign ev_ri0_o  = ok & pend_ri_q & ~last_q & (rd_ri_i != exp_ri_q);
  assign ev_ril_o  = ok & pend_ri_q &  last_q & (rd_ri_i != exp_ri_q);
  assign ev_pj_o   = ok & pend_pj_q & (rd_pj_i != exp_pj_q);

  assert_req_pend_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> (pend && rd_sel_o != 2'b00));
  assert_req_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !vs_i) |=> !rd_req_o);
  assert_take_once_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> !pend);
  assert_quiet_off_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !(ev_miss_o || ev_ri0_o || ev_ril_o || ev_pj_o));
endmodule

// File: rtl/lcm_evt_stat.sv
`timescale 1ns/1ps
module lcm_evt_stat #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] unmask_i,
  output logic [N-1:0] status_o,
  output logic         irq_o
);
  logic [N-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= (st_q & ~clr_i) | set_i;
  end

  assign status_o = st_q;
  assign irq_o    = |(st_q & unmask_i);

  assert_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((status_o & $past(set_i)) == $past(set_i)));
  assert_w1c_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_i)) |=> ((status_o & $past(clr_i & ~set_i)) == '0));
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && clr_i == '0) |=> $stable(status_o));
endmodule

// File: rtl/link_check_mon.sv
`timescale 1ns/1ps
module link_check_mon
  import lcm_pkg::*;
#(
  parameter int RI_W   = 16,
  parameter int PJ_W   = 8,
  parameter int FC_W   = 7,
  parameter int PJ_LOG = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            enable_i,
  input  logic            vsync_i,
  input  logic [RI_W-1:0] local_ri_i,
  input  logic [PJ_W-1:0] local_pj_i,
  output logic            rd_req_o,
  output logic [1:0]      rd_sel_o,
  input  logic            rd_done_i,
  input  logic            rd_err_i,
  input  logic [RI_W-1:0] rd_ri_i,
  input  logic [PJ_W-1:0] rd_pj_i,
  input  logic [NEV-1:0]  unmask_i,
  input  logic [NEV-1:0]  clr_i,
  output logic [NEV-1:0]  status_o,
  output logic            irq_o
);
  logic vs, ri_first, ri_last, pj_pt, pj_first;
  logic ev_ri0, ev_ril, ev_pj, ev_miss;
  logic [RI_W-1:0] ri0_q;
  logic [PJ_W-1:0] pj0_q;
  logic [NEV-1:0]  set;

  lcm_frame_ctr #(.FC_W(FC_W), .PJ_LOG(PJ_LOG)) u_fc (
    .clk_i, .rst_ni, .en_i(enable_i), .vsync_i,
    .vs_o(vs), .ri_first_o(ri_first), .ri_last_o(ri_last),
    .pj_pt_o(pj_pt), .pj_first_o(pj_first)
  );

  lcm_rd_track #(.RI_W(RI_W), .PJ_W(PJ_W)) u_rd (
    .clk_i, .rst_ni, .en_i(enable_i), .vs_i(vs),
    .ri_first_i(ri_first), .ri_last_i(ri_last), .pj_pt_i(pj_pt),
    .local_ri_i, .local_pj_i, .rd_done_i, .rd_err_i, .rd_ri_i, .rd_pj_i,
    .rd_req_o, .rd_sel_o,
    .ev_ri0_o(ev_ri0), .ev_ril_o(ev_ril), .ev_pj_o(ev_pj), .ev_miss_o(ev_miss)
  );

  // frame-0 snapshots for the stuck tests
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ri0_q <= '0;
      pj0_q <= '0;
    end else if (ri_first) begin
      ri0_q <= local_ri_i;
      pj0_q <= local_pj_i;
    end
  end

  always_comb begin
    set              = '0;
    set[EV_RI_TICK]  = ri_last;
    set[EV_PJ_TICK]  = pj_pt;
    set[EV_RI_F0]    = ev_ri0;
    set[EV_RI_FL]    = ev_ril;
    set[EV_RI_STUCK] = ri_last & (local_ri_i == ri0_q);
    set[EV_PJ_FAIL]  = ev_pj;
    set[EV_PJ_STUCK] = pj_first & (local_pj_i == pj0_q);
    set[EV_RD_MISS]  = ev_miss;
  end

  lcm_evt_stat #(.N(NEV)) u_st (
    .clk_i, .rst_ni, .set_i(set), .clr_i, .unmask_i,
    .status_o, .irq_o
  );

  assert_tick_nest_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ri_last |-> pj_pt);
  assert_irq_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|status_o));
endmodule

// File: tb/tb_link_check_mon.sv
`timescale 1ns/1ps
module tb_link_check_mon;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enable_i = 1'b0;
  logic        vsync_i = 1'b0;
  logic [15:0] local_ri_i = '0;
  logic [7:0]  local_pj_i = '0;
  logic        rd_req_o;
  logic [1:0]  rd_sel_o;
  logic        rd_done_i = 1'b0;
  logic        rd_err_i = 1'b0;
  logic [15:0] rd_ri_i = '0;
  logic [7:0]  rd_pj_i = '0;
  logic [7:0]  unmask_i = '0;
  logic [7:0]  clr_i = '0;
  logic [7:0]  status_o;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  link_check_mon dut (
    .clk_i(clk), .rst_ni, .enable_i, .vsync_i, .local_ri_i, .local_pj_i,
    .rd_req_o, .rd_sel_o, .rd_done_i, .rd_err_i, .rd_ri_i, .rd_pj_i,
    .unmask_i, .clr_i, .status_o, .irq_o
  );

  typedef struct packed {
    logic [15:0] m0;
    logic [15:0] ml;
    logic [7:0]  mpj;
    logic        sri;
    logic        spj;
    logic        drop;
    logic        err;
    logic [7:0]  exp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{16'h0000, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h03},
    '{16'h0100, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h07},
    '{16'h0000, 16'h8000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0B},
    '{16'h0000, 16'h0000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h13},
    '{16'h0000, 16'h0000, 8'h40, 1'b0, 1'b0, 1'b0, 1'b0, 8'h23},
    '{16'h0000, 16'h0000, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h43},
    '{16'h0000, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h83},
    '{16'h0000, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h83},
    '{16'h0001, 16'h0002, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 8'h2F}
  };

  function automatic logic [15:0] ri_of(input int f);
    return 16'(32'hA5A5 ^ (f * 257));
  endfunction
  function automatic logic [7:0] pj_of(input int f);
    return 8'(32'h3C + f);
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one 8-cycle frame: pulse, request check, optional response
  task automatic do_frame(input int f, input logic [15:0] ri, input logic [7:0] pj,
                          input logic [15:0] rm, input logic [7:0] pm,
                          input bit respond, input bit err, input bit clr_vs);
    logic [1:0] es;
    @(negedge clk);
    local_ri_i = ri; local_pj_i = pj; vsync_i = 1'b1;
    if (clr_vs) clr_i = '1;
    @(negedge clk);
    vsync_i = 1'b0; clr_i = '0;
    es = {f % 16 == 15, f == 0 || f == 127};
    chk($sformatf("R3 req/sel frame %0d", f), {rd_req_o, (rd_req_o ? rd_sel_o : 2'b00)},
        {|es, es});
    if (es != 2'b00 && respond) begin
      @(negedge clk);
      chk("R3 req one cycle", rd_req_o, 1'b0);
      rd_done_i = 1'b1; rd_err_i = err;
      rd_ri_i = ri ^ rm; rd_pj_i = pj ^ pm;
      @(negedge clk);
      rd_done_i = 1'b0; rd_err_i = 1'b0;
      idle(4);
    end else idle(6);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    chk("R10 reset status", status_o, 8'h00);
    chk("R11 reset irq", irq_o, 1'b0);
    chk("R3 reset req", rd_req_o, 1'b0);
    rst_ni = 1'b1;
    idle(2);
    enable_i = 1'b1;

    // vector walk: one full 128-frame window each
    for (int v = 0; v < NV; v++) begin
      for (int f = 0; f < 128; f++) begin
        logic [15:0] ri;
        logic [7:0]  pj;
        ri = (VECS[v].sri && f == 127) ? ri_of(0) : ri_of(f);
        pj = (VECS[v].spj && f == 15) ? pj_of(0) : pj_of(f);
        do_frame(f, ri, pj,
                 (f == 0) ? VECS[v].m0 : (f == 127) ? VECS[v].ml : 16'h0,
                 VECS[v].mpj,
                 !(VECS[v].drop && f == 47), VECS[v].err && f == 31, 1'b0);
      end
      chk($sformatf("R2 ticks v%0d", v), status_o[1:0], VECS[v].exp[1:0]);
      chk($sformatf("R4 ri frame0 v%0d", v), status_o[2], VECS[v].exp[2]);
      chk($sformatf("R5 ri frame127 v%0d", v), status_o[3], VECS[v].exp[3]);
      chk($sformatf("R6 ri stuck v%0d", v), status_o[4], VECS[v].exp[4]);
      chk($sformatf("R7 pj fail v%0d", v), status_o[5], VECS[v].exp[5]);
      chk($sformatf("R8 pj stuck v%0d", v), status_o[6], VECS[v].exp[6]);
      chk($sformatf("R9 late/err v%0d", v), status_o[7], VECS[v].exp[7]);
      unmask_i = VECS[v].exp;
      #1 chk($sformatf("R11 irq on v%0d", v), irq_o, 1'b1);
      unmask_i = ~VECS[v].exp;
      #1 chk($sformatf("R11 irq off v%0d", v), irq_o, 1'b0);
      unmask_i = '0;
      @(negedge clk); clr_i = '1;
      @(negedge clk); clr_i = '0;
      chk($sformatf("R10 w1c v%0d", v), status_o, 8'h00);
    end

    // R12: disabled, pulses and strobes do nothing
    enable_i = 1'b0;
    @(negedge clk); vsync_i = 1'b1; rd_done_i = 1'b1; rd_err_i = 1'b1;
    @(negedge clk); vsync_i = 1'b0; rd_done_i = 1'b0; rd_err_i = 1'b0;
    chk("R12 no req while off", rd_req_o, 1'b0);
    idle(2);
    chk("R12 no events while off", status_o, 8'h00);

    // R1: re-enable restarts at frame 0; R9: strobe with next vsync is late
    enable_i = 1'b1;
    do_frame(0, 16'h1234, 8'h11, 16'h0, 8'h0, 1'b0, 1'b0, 1'b0);
    chk("R1 restart at frame 0 no event", status_o, 8'h00);
    @(negedge clk);
    vsync_i = 1'b1; local_ri_i = 16'h1111;
    rd_done_i = 1'b1; rd_ri_i = 16'hFFFF;
    @(negedge clk);
    vsync_i = 1'b0; rd_done_i = 1'b0;
    chk("R9 same-cycle strobe is late only", status_o, 8'h80);
    @(negedge clk); clr_i = '1;
    @(negedge clk); clr_i = '0;
    // R9: strobe with nothing outstanding is ignored
    rd_done_i = 1'b1; rd_err_i = 1'b1; rd_ri_i = 16'hDEAD;
    @(negedge clk); rd_done_i = 1'b0; rd_err_i = 1'b0;
    idle(1);
    chk("R9 idle strobe ignored", status_o, 8'h00);

    // R10: event wins over clear in the same cycle (frame 15 tick)
    enable_i = 1'b0; @(negedge clk); enable_i = 1'b1;
    for (int f = 0; f < 16; f++)
      do_frame(f, ri_of(f), pj_of(f), 16'h0, 8'h0, 1'b1, 1'b0, f == 15);
    chk("R10 set beats clear", status_o, 8'h02);
    unmask_i = 8'h01;
    #1 chk("R11 masked", irq_o, 1'b0);
    unmask_i = 8'h02;
    #1 chk("R11 unmasked", irq_o, 1'b1);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule